// File: doc/BRIEF.md
# Boot-Time Configuration Programming Sequencer

This block takes the place of the software bring-up of a clock ramp controller. Once reset is released, or when a start pulse arrives, it becomes the master of a simple memory-mapped bus and programs the controller without any outside help. The sequencer works through fixed groups of configuration words. A group of limits words comes first. A group of frequency-scaling words follows, and then a link word. The last stage enables ramping in three steps. Every group follows the same pattern. The sequencer first checks that the controller is ready. It then writes the group's words. Last, it runs one update handshake for each word it wrote, and each handshake carries an entry ID one lower than the one before it.

Every poll is supervised by a timer that counts in microseconds, derived from the clock frequency parameter. A poll that stays unsatisfied for the whole timeout window aborts the run and sets a sticky error. A stop request given while the block is idle runs a single disable group. The bus port is a plain request/ready interface. `bus_req` stays high until the slave raises `bus_ready` for one cycle. Read data is taken in the same cycle as that ready pulse.

Top module: `cfg_seq_top`

## Requirements
- R1: While reset is asserted, bus_req, busy, done and error are all 0.
- R2: A run starts with no pulse after reset (AUTO_START=1), or on a start pulse. It programs the groups in this order. Limits: ID 6, 3 words at 0x30+4i. Frequency scaling: ID 14, 8 words at 0x10+4i. Link: ID 3, 1 word at 0x40. Three ramp groups follow, each with ID 2 and one word at 0x50: 0x800, then 0xC00, then 0x400. Word i of table group g (limits g=0, scaling g=1, link g=2) carries 0x10000000*(g+1) + 0x00010101*(i+1).
- R3: Each group starts by reading the command register at 0x00 and writing it back with bit 1 set. It then polls that register until bit 0 reads 0. No table word of the group is written before bit 0 reads 0.
- R4: A group of n words is followed by n handshakes with IDs base, base-1, down to base-n+1. Each handshake on the update register at 0x60 runs in five steps. (1) A read-modify-write ORs the ID into bits 3:0. (2) A read-modify-write sets bit 8. (3) The sequencer polls until bit 16+ID reads 1. (4) It writes 0. (5) It polls until bits 31:16 read 0.
- R5: After a failed poll read, the next read of the same register comes about one microsecond later, that is CLK_HZ/1e6 cycles, within a few cycles.
- R6: If a poll is not satisfied within TIMEOUT_US microseconds, the run aborts. error goes to 1, busy and done are 0, and no further bus request is made. error stays 1 until the next start pulse.
- R7: A start pulse while idle clears error in the next cycle and runs the complete sequence again.
- R8: busy is 1 for the whole run. done goes to 1 only after the last stage has succeeded, and it is cleared when a run is launched. done and error are never 1 together.
- R9: A stop pulse while idle with error 0 runs one group: ID 2, word 0x0 written to 0x50, with its ready check and handshake. done is 1 afterwards. Start and stop pulses are ignored while busy, and stop is ignored while error is 1.
- R10: Every set-bit operation is a read followed by a write of the value read with the bits ORed in. Other bits of the register are kept. A command register that reads 0xA0 is written as 0xA2.
- R11: While bus_req is 1 and bus_ready is 0, the next cycle keeps bus_req at 1 and bus_we, bus_addr and bus_wdata unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches the bring-up sequence |
| stop | input | 1 | Pulse that launches the disable group |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte offset of the register |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Slave completes the transaction |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| done | output | 1 | Last run finished successfully |
| busy | output | 1 | A run is in progress |
| error | output | 1 | Sticky timeout error |

## Verification
The hardest situation to reach from the ports is a timeout: a poll that fails for a full 500 µs window. A well-behaved slave never causes one. The bench slave model therefore has two fault switches. One holds the command-register ready bit high, which makes the ready check time out before any table word is written. The other suppresses the acknowledge bits, which makes a handshake time out partway through the limits group. The bench times the abort window, counts the writes logged up to the abort, checks that error stays set, and checks that a later start recovers. A second hard case is the poll interval. The model replies to the first two command reads after each write with the ready bit still high, so every group makes timed retries, and the model records the gaps between those retries.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int DATA_W  = 32;
    localparam int OFS_W   = 8;
    localparam int ID_W    = 4;
    localparam int MAX_LEN = 8;
    localparam int IDX_W   = $clog2(MAX_LEN + 1);

    // register offsets in the slave
    localparam logic [OFS_W-1:0] CMD_OFS  = 8'h00;
    localparam logic [OFS_W-1:0] UPD_OFS  = 8'h60;
    localparam logic [OFS_W-1:0] DFS_OFS  = 8'h10;
    localparam logic [OFS_W-1:0] LMH_OFS  = 8'h30;
    localparam logic [OFS_W-1:0] LINK_OFS = 8'h40;
    localparam logic [OFS_W-1:0] RAMP_OFS = 8'h50;

    localparam logic [DATA_W-1:0] ROOT_BIT = 32'h0000_0002;
    localparam logic [DATA_W-1:0] SYNC_BIT = 32'h0000_0100;

    typedef enum logic [2:0] {
        ST_LMH, ST_DFS, ST_LINK, ST_RAMP0, ST_RAMP1, ST_RAMP2, ST_OFF
    } stage_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_CMD_RD, PH_CMD_WR, PH_RDY_POLL, PH_RDY_WAIT, PH_BURST,
        PH_ID_RD, PH_ID_WR, PH_EN_RD, PH_EN_WR, PH_ACK_POLL, PH_ACK_WAIT,
        PH_CLR_WR, PH_CLR_POLL, PH_CLR_WAIT
    } phase_e;

    function automatic logic [IDX_W-1:0] grp_len(stage_e s);
        case (s)
            ST_LMH:  return IDX_W'(3);
            ST_DFS:  return IDX_W'(8);
            default: return IDX_W'(1);
        endcase
    endfunction

    function automatic logic [ID_W-1:0] grp_id(stage_e s);
        case (s)
            ST_LMH:  return ID_W'(6);
            ST_DFS:  return ID_W'(14);
            ST_LINK: return ID_W'(3);
            default: return ID_W'(2);
        endcase
    endfunction

    function automatic logic [OFS_W-1:0] ent_ofs(stage_e s, logic [IDX_W-1:0] i);
        logic [OFS_W-1:0] step;
        step = OFS_W'(i) << 2;
        case (s)
            ST_LMH:  return LMH_OFS + step;
            ST_DFS:  return DFS_OFS + step;
            ST_LINK: return LINK_OFS;
            default: return RAMP_OFS;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ent_data(stage_e s, logic [IDX_W-1:0] i);
        case (s)
            ST_RAMP0: return 32'h0000_0800;
            ST_RAMP1: return 32'h0000_0C00;
            ST_RAMP2: return 32'h0000_0400;
            ST_OFF:   return 32'h0000_0000;
            default:  return (32'(s) + 32'd1) * 32'h1000_0000
                           + (32'(i) + 32'd1) * 32'h0001_0101;
        endcase
    endfunction

endpackage

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TIMEOUT_US = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick,
    output logic expired
);
    localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int DIV_W = $clog2(DIV + 1);
    localparam int CNT_W = $clog2(TIMEOUT_US + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        tick    = 1'b0;
        expired = (t_q.cnt == CNT_W'(TIMEOUT_US));
        if (clr) begin
            t_d.div = '0;
            t_d.cnt = '0;
        end else if (t_q.div == DIV_W'(DIV - 1)) begin
            tick    = 1'b1;
            t_d.div = '0;
            if (!expired) t_d.cnt = t_q.cnt + CNT_W'(1);
        end else begin
            t_d.div = t_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/cfg_seq_table.sv
module cfg_seq_table
    import cfg_seq_pkg::*;
(
    input  stage_e             stage,
    input  logic [IDX_W-1:0]   idx,
    output logic [OFS_W-1:0]   ofs,
    output logic [DATA_W-1:0]  data,
    output logic [ID_W-1:0]    base_id,
    output logic [IDX_W-1:0]   len
);
    always_comb begin
        ofs     = ent_ofs(stage, idx);
        data    = ent_data(stage, idx);
        base_id = grp_id(stage);
        len     = grp_len(stage);
    end
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TIMEOUT_US = 500,
    parameter int ADDR_W     = 8,
    parameter bit AUTO_START = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic              busy,
    output logic              error
);
    typedef struct packed {
        phase_e             phase;
        stage_e             stage;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   hs;
        logic [DATA_W-1:0]  tmp;
        logic               boot;
        logic               done;
        logic               error;
    } seq_t;

    seq_t s_d, s_q;

    logic [OFS_W-1:0]  tbl_ofs;
    logic [DATA_W-1:0] tbl_data;
    logic [ID_W-1:0]   base_id;
    logic [IDX_W-1:0]  len;
    logic [ID_W-1:0]   cur_id;
    logic [15:0]       ack_vec;
    logic [OFS_W-1:0]  ofs;
    logic              xfer, tick, expired, tmr_clr, last_hs;

    cfg_seq_table i_table (
        .stage   (s_q.stage),
        .idx     (s_q.idx),
        .ofs     (tbl_ofs),
        .data    (tbl_data),
        .base_id (base_id),
        .len     (len)
    );

    cfg_seq_timer #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tick),
        .expired (expired)
    );

    always_comb begin
        tmr_clr = 1'b1;
        case (s_q.phase)
            PH_RDY_POLL, PH_RDY_WAIT, PH_ACK_POLL,
            PH_ACK_WAIT, PH_CLR_POLL, PH_CLR_WAIT: tmr_clr = 1'b0;
            default: ;
        endcase
    end

    assign cur_id  = base_id - ID_W'(s_q.hs);
    assign ack_vec = bus_rdata[31:16];
    assign last_hs = (s_q.hs == len - IDX_W'(1));

    // bus drive decoded from the registered phase
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        ofs       = CMD_OFS;
        bus_wdata = '0;
        case (s_q.phase)
            PH_CMD_RD, PH_RDY_POLL: bus_req = 1'b1;
            PH_CMD_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = s_q.tmp | ROOT_BIT;
            end
            PH_BURST: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                ofs       = tbl_ofs;
                bus_wdata = tbl_data;
            end
            PH_ID_RD, PH_EN_RD, PH_ACK_POLL, PH_CLR_POLL: begin
                bus_req = 1'b1;
                ofs     = UPD_OFS;
            end
            PH_ID_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                ofs       = UPD_OFS;
                bus_wdata = s_q.tmp | DATA_W'(cur_id);
            end
            PH_EN_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                ofs       = UPD_OFS;
                bus_wdata = s_q.tmp | SYNC_BIT;
            end
            PH_CLR_WR: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                ofs     = UPD_OFS;
            end
            default: ;
        endcase
        bus_addr = ADDR_W'(ofs);
    end

    assign xfer = bus_req && bus_ready;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (start || s_q.boot) begin
                    s_d.boot  = 1'b0;
                    s_d.error = 1'b0;
                    s_d.done  = 1'b0;
                    s_d.stage = ST_LMH;
                    s_d.phase = PH_CMD_RD;
                end else if (stop && !s_q.error) begin
                    s_d.done  = 1'b0;
                    s_d.stage = ST_OFF;
                    s_d.phase = PH_CMD_RD;
                end
            end
            PH_CMD_RD: if (xfer) begin
                s_d.tmp   = bus_rdata;
                s_d.phase = PH_CMD_WR;
            end
            PH_CMD_WR: if (xfer) s_d.phase = PH_RDY_POLL;
            PH_RDY_POLL: if (xfer) begin
                s_d.idx   = '0;
                s_d.phase = bus_rdata[0] ? PH_RDY_WAIT : PH_BURST;
            end
            PH_BURST: if (xfer) begin
                if (s_q.idx == len - IDX_W'(1)) begin
                    s_d.hs    = '0;
                    s_d.phase = PH_ID_RD;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end
            end
            PH_ID_RD: if (xfer) begin
                s_d.tmp   = bus_rdata;
                s_d.phase = PH_ID_WR;
            end
            PH_ID_WR: if (xfer) s_d.phase = PH_EN_RD;
            PH_EN_RD: if (xfer) begin
                s_d.tmp   = bus_rdata;
                s_d.phase = PH_EN_WR;
            end
            PH_EN_WR: if (xfer) s_d.phase = PH_ACK_POLL;
            PH_ACK_POLL: if (xfer)
                s_d.phase = ack_vec[cur_id] ? PH_CLR_WR : PH_ACK_WAIT;
            PH_CLR_WR: if (xfer) s_d.phase = PH_CLR_POLL;
            PH_CLR_POLL: if (xfer) begin
                if (ack_vec != '0) begin
                    s_d.phase = PH_CLR_WAIT;
                end else if (!last_hs) begin
                    s_d.hs    = s_q.hs + IDX_W'(1);
                    s_d.phase = PH_ID_RD;
                end else if (s_q.stage == ST_RAMP2 || s_q.stage == ST_OFF) begin
                    s_d.done  = 1'b1;
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.stage = stage_e'(s_q.stage + 3'd1);
                    s_d.phase = PH_CMD_RD;
                end
            end
            PH_RDY_WAIT, PH_ACK_WAIT, PH_CLR_WAIT: begin
                if (expired) begin
                    s_d.error = 1'b1;
                    s_d.phase = PH_IDLE;
                end else if (tick) begin
                    s_d.phase = (s_q.phase == PH_RDY_WAIT) ? PH_RDY_POLL :
                                (s_q.phase == PH_ACK_WAIT) ? PH_ACK_POLL : PH_CLR_POLL;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.stage <= ST_LMH;
            s_q.boot  <= AUTO_START;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = (s_q.phase != PH_IDLE);
    assign done  = s_q.done;
    assign error = s_q.error;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ready,
    input logic              done,
    input logic              busy,
    input logic              error
);
    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R8
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R6
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);
endmodule

bind cfg_seq_top cfg_seq_chk #(.ADDR_W(ADDR_W)) i_cfg_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .done      (done),
    .busy      (busy),
    .error     (error)
);

// File: tb/test_cfg_seq_top.sv
`timescale 1ns/1ps
module test_cfg_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        bus_req, bus_we, bus_ready;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        done, busy, error;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    cfg_seq_top i_cfg_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .done(done), .busy(busy), .error(error)
    );

    // ---------------- slave model ----------------
    logic        stuck = 1'b0, no_ack = 1'b0, log_clr = 1'b0;
    logic [31:0] cmd_r, upd_r;
    logic [15:0] ack_r;
    logic        ack_set;
    logic [3:0]  ack_id;
    int          ack_cnt, busy_left, cyc, last_rd, gap_min, gap_max, wcnt;
    logic        last_busy, viol;
    logic [7:0]  la [128];
    logic [31:0] ld [128];

    assign bus_rdata = (bus_addr == 8'h00) ? {cmd_r[31:1], (busy_left != 0) || stuck} :
                       (bus_addr == 8'h60) ? {ack_r, upd_r[15:0]} : 32'h0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ready <= 1'b0; cmd_r <= 32'hA0; upd_r <= '0; ack_r <= '0;
            ack_set <= 1'b0; ack_id <= '0; ack_cnt <= 0; busy_left <= 0;
            cyc <= 0; last_rd <= 0; gap_min <= 1000000; gap_max <= 0;
            wcnt <= 0; last_busy <= 1'b0; viol <= 1'b0;
        end else begin
            cyc <= cyc + 1;
            bus_ready <= bus_req && !bus_ready;
            if (log_clr) begin
                wcnt <= 0; viol <= 1'b0; gap_min <= 1000000; gap_max <= 0; last_busy <= 1'b0;
            end
            if (ack_cnt > 0) begin
                ack_cnt <= ack_cnt - 1;
                if (ack_cnt == 1) ack_r <= ack_set ? (16'h1 << ack_id) : 16'h0;
            end
            if (bus_req && bus_ready) begin
                if (bus_we) begin
                    if (wcnt < 128) begin la[wcnt] <= bus_addr; ld[wcnt] <= bus_wdata; end
                    wcnt <= wcnt + 1;
                    if (bus_addr == 8'h00) begin
                        cmd_r <= bus_wdata & ~32'h1;
                        busy_left <= 2;
                    end else if (bus_addr == 8'h60) begin
                        upd_r <= bus_wdata;
                        if (bus_wdata[8] && !no_ack) begin
                            ack_set <= 1'b1; ack_id <= bus_wdata[3:0]; ack_cnt <= 3;
                        end else if (bus_wdata == 32'h0) begin
                            ack_set <= 1'b0; ack_cnt <= 3;
                        end
                    end else if (busy_left != 0 || stuck) begin
                        viol <= 1'b1;
                    end
                end else if (bus_addr == 8'h00) begin
                    if (last_busy) begin
                        if (cyc - last_rd < gap_min) gap_min <= cyc - last_rd;
                        if (cyc - last_rd > gap_max) gap_max <= cyc - last_rd;
                    end
                    last_rd   <= cyc;
                    last_busy <= (busy_left != 0) || stuck;
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end
            end
        end
    end

    // ---------------- expected group vectors ----------------
    typedef struct packed {
        logic [3:0]  id;
        logic [3:0]  n;
        logic [7:0]  a0;
        logic        fixed;
        logic [31:0] d;
    } grp_t;

    localparam grp_t GRP [0:6] = '{
        '{4'd6,  4'd3, 8'h30, 1'b0, 32'h0},
        '{4'd14, 4'd8, 8'h10, 1'b0, 32'h0},
        '{4'd3,  4'd1, 8'h40, 1'b0, 32'h0},
        '{4'd2,  4'd1, 8'h50, 1'b1, 32'h800},
        '{4'd2,  4'd1, 8'h50, 1'b1, 32'hC00},
        '{4'd2,  4'd1, 8'h50, 1'b1, 32'h400},
        '{4'd2,  4'd1, 8'h50, 1'b1, 32'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_wr(input int j, input logic [7:0] a, input logic [31:0] d, input string req);
        if (j < 128) begin
            chk(la[j] == a, req, {24'h0, la[j]}, {24'h0, a});
            chk(ld[j] == d, req, ld[j], d);
        end
    endtask

    task automatic check_log(input int first, input int last);
        int j = 0;
        for (int g = first; g <= last; g++) begin
            chk_wr(j, 8'h00, 32'hA2, "R10 cmd rmw"); j++;
            for (int i = 0; i < int'(GRP[g].n); i++) begin
                chk_wr(j, GRP[g].a0 + 8'(4 * i),
                       GRP[g].fixed ? GRP[g].d :
                       32'(g + 1) * 32'h1000_0000 + 32'(i + 1) * 32'h0001_0101,
                       "R2 burst");
                j++;
            end
            for (int k = 0; k < int'(GRP[g].n); k++) begin
                logic [31:0] id = 32'(GRP[g].id) - 32'(k);
                chk_wr(j, 8'h60, id, "R4 id set");          j++;
                chk_wr(j, 8'h60, id | 32'h100, "R4 sync");  j++;
                chk_wr(j, 8'h60, 32'h0, "R4 clear");        j++;
            end
        end
        chk(wcnt == j, "R2 write count", 32'(wcnt), 32'(j));
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    task automatic clear_log();
        log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        int t = 0;
        @(negedge clk);
        while (busy && t < limit) begin @(negedge clk); t++; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_req == 1'b0, "R1 req", 32'(bus_req), 0);
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(error == 1'b0, "R1 error", 32'(error), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 auto start busy", 32'(busy), 1);
        repeat (20) @(negedge clk);
        pulse_start();
        pulse_stop();   // R9 ignored while busy
        wait_end(20000);
        chk(done == 1'b1, "R8 done", 32'(done), 1);
        chk(error == 1'b0, "R8 error", 32'(error), 0);
        check_log(0, 5);
        chk(viol == 1'b0, "R3 write before ready", 32'(viol), 0);
        chk(gap_max >= 45 && gap_max <= 55, "R5 poll gap max", 32'(gap_max), 50);
        chk(gap_min >= 45 && gap_min <= 55, "R5 poll gap min", 32'(gap_min), 50);

        // R9 disable group
        clear_log();
        pulse_stop();
        chk(done == 1'b0 && busy == 1'b1, "R9 launch", {30'h0, done, busy}, 32'h1);
        wait_end(20000);
        chk(done == 1'b1, "R9 done", 32'(done), 1);
        check_log(6, 6);

        // R6 ready-check timeout
        clear_log();
        stuck = 1'b1;
        pulse_start();
        begin
            int t = 0;
            while (!error && t < 40000) begin @(negedge clk); t++; end
            chk(t >= 24500 && t <= 25600, "R6 timeout window", 32'(t), 25000);
        end
        chk(busy == 1'b0 && done == 1'b0, "R6 abort state", {30'h0, done, busy}, 0);
        chk(wcnt == 1, "R6 no table writes", 32'(wcnt), 1);
        repeat (200) @(negedge clk);
        chk(error == 1'b1, "R6 sticky", 32'(error), 1);
        pulse_stop();
        repeat (50) @(negedge clk);
        chk(wcnt == 1 && error == 1'b1 && busy == 1'b0, "R9 stop ignored on error", 32'(wcnt), 1);

        // R7 restart clears error
        stuck = 1'b0;
        clear_log();
        pulse_start();
        chk(error == 1'b0 && busy == 1'b1, "R7 clear", {30'h0, error, busy}, 32'h1);
        wait_end(20000);
        chk(done == 1'b1 && error == 1'b0, "R7 rerun done", {30'h0, done, error}, 32'h2);
        chk(wcnt == 66, "R7 rerun writes", 32'(wcnt), 66);

        // R6 handshake acknowledge timeout
        no_ack = 1'b1;
        clear_log();
        pulse_start();
        wait_end(40000);
        chk(error == 1'b1 && done == 1'b0, "R6 ack timeout", {30'h0, error, done}, 32'h2);
        chk(wcnt == 6, "R6 writes before abort", 32'(wcnt), 6);
        chk(bus_req == 1'b0, "R6 bus quiet", 32'(bus_req), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule